// File: doc/BRIEF.md
# Modular Exponentiation Engine with Selectable Timing Behaviour

This block computes `base ^ exponent mod modulus` on 32-bit operands. It first reduces the base, then walks the exponent bits and issues a series of modular multiplications to a bit-serial multiplier. A single-cycle `start` loads all three operands. A single-cycle `ready` pulse presents the result, and the number of cycles since `start` appears on a latency output.

A build-time parameter picks one of five exponent walks:
- `ARCH_RTL`: scans from the low bit upward.
- `ARCH_LTR`: scans from the high bit downward.
- `ARCH_LTR_DUMMY`: the high-to-low walk, but a multiply is always issued and its product is discarded when the bit is 0.
- `ARCH_LADDER`: every bit costs one multiply plus one square, whatever its value.
- `ARCH_CONST`: pads with idle cycles up to a fixed deadline.

The first two leak the exponent through the moment `ready` rises; the other three trade cycles for a flatter timing profile. A second parameter, `BAL_SUB`, makes the multiplier spend its correction cycle on every bit, so its own latency no longer depends on the operands.

Because all variants share one interface, their latency can be compared directly.

Top module: `modexp_core`

## Requirements
- R1: For every modulus of 1 or more and in every variant, `result` equals base^exponent mod modulus. A base at or above the modulus is reduced first, and a modulus of 1 yields 0.
- R2: A zero modulus gives `result` 0 and a `ready` pulse one cycle after `start` is accepted, with `latency` reading 1, in every variant.
- R3: `ready` is high for exactly one cycle per accepted start.
- R4: A `start` raised while an operation is in progress is ignored. No extra `ready` pulse appears, and the running result is unchanged.
- R5: After reset, `ready` is 0, `result` is 0 and `latency` is 0.
- R6: The constant-time variant reports `latency` equal to `CT_CYCLES` (default 4500) for every nonzero modulus, whatever the base and exponent.
- R7: With `BAL_SUB` set, the always-multiply and ladder variants take exactly (2W+2) + (2W+3)*2W + 1 cycles, which is 4355 for W = 32, for every nonzero modulus.
- R8: In both unmitigated variants, an all-ones exponent takes more cycles than a zero exponent for the same base and modulus.
- R9: A zero exponent yields 1 for any modulus above 1.
- R10: Every product the multiplier delivers is below the modulus.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse, taken only when idle |
| base | input | W | Base operand |
| expo | input | W | Exponent (the secret) |
| modulus | input | W | Modulus, odd and nonzero for normal use |
| ready | output | 1 | One-cycle result-valid pulse |
| result | output | W | Modular power, held until the next ready |
| latency | output | CW | Cycles from accepted start to ready |

## Verification
The bench aims at the degenerate operands:
- A zero modulus must bypass the multiplier entirely and finish in one cycle.
- A unit modulus must return 0 rather than the initial value 1.
- A base above the modulus must be reduced before use; without that, the multiplier's bound is violated and results go wrong.

It also relaunches `start` mid-operation. A design that restarted would emit the second operand set's result or a second `ready`.

Across all variants it pins the exact cycle counts of the balanced and padded walks, so any stray skip or uneven padding shows up as a latency mismatch. Separately, it confirms that the unmitigated walks really do vary with the exponent.

// File: rtl/modexp_pkg.sv
`timescale 1ns/1ps
package modexp_pkg;
  // Exponent walk selection
  typedef enum logic [2:0] {
    ARCH_RTL       = 3'd0,
    ARCH_LTR       = 3'd1,
    ARCH_LTR_DUMMY = 3'd2,
    ARCH_LADDER    = 3'd3,
    ARCH_CONST     = 3'd4
  } arch_e;

  // Operand source for one multiplication
  typedef enum logic [1:0] {
    SRC_R0 = 2'd0,
    SRC_R1 = 2'd1,
    SRC_X  = 2'd2
  } src_e;

  // One multiplication slot within a bit step
  typedef struct packed {
    logic run;   // issue a multiply in this slot
    logic wr;    // keep the product
    src_e sa;    // first operand (must be reduced)
    src_e sb;    // second operand
    logic dst;   // 0 = r0, 1 = r1
  } mulop_t;
endpackage

// File: rtl/modmul_serial.sv
`timescale 1ns/1ps
module modmul_serial #(
  parameter int W       = 32,
  parameter bit BAL_SUB = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] m,
  output logic         done,
  output logic [W-1:0] p
);
  localparam int IW = $clog2(W);
  localparam int TW = W + 2;

  typedef enum logic [1:0] {M_IDLE, M_STEP, M_FIX} mst_e;
  mst_e st;

  logic [W-1:0]  a_q, b_q, m_q, acc;
  logic [TW-1:0] t_q, t_nx, mx, m2, fix_v;
  logic [IW-1:0] idx;
  logic          last;

  assign mx    = {2'b00, m_q};
  assign m2    = {1'b0, m_q, 1'b0};
  // Horner step: double the accumulator, add a when the scanned bit is set
  assign t_nx  = {1'b0, acc, 1'b0} + (b_q[idx] ? {2'b00, a_q} : {TW{1'b0}});
  // t_q < 3m, so at most two subtractions bring it below m
  assign fix_v = (t_q >= m2) ? (t_q - m2) : ((t_q >= mx) ? (t_q - mx) : t_q);
  assign last  = (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= M_IDLE;
      done <= 1'b0;
      p    <= '0;
      acc  <= '0;
      t_q  <= '0;
      idx  <= '0;
      a_q  <= '0;
      b_q  <= '0;
      m_q  <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        M_IDLE: begin
          if (start) begin
            a_q <= a;
            b_q <= b;
            m_q <= m;
            acc <= '0;
            idx <= IW'(W - 1);
            st  <= M_STEP;
          end
        end
        M_STEP: begin
          if (!BAL_SUB && (t_nx < mx)) begin
            acc <= t_nx[W-1:0];
            if (last) begin
              done <= 1'b1;
              p    <= t_nx[W-1:0];
              st   <= M_IDLE;
            end else begin
              idx <= idx - 1'b1;
            end
          end else begin
            t_q <= t_nx;
            st  <= M_FIX;
          end
        end
        M_FIX: begin
          acc <= fix_v[W-1:0];
          if (last) begin
            done <= 1'b1;
            p    <= fix_v[W-1:0];
            st   <= M_IDLE;
          end else begin
            idx <= idx - 1'b1;
            st  <= M_STEP;
          end
        end
        default: st <= M_IDLE;
      endcase
    end
  end

  // R10: every delivered product is reduced
  a_r10_product_reduced: assert property (@(posedge clk) disable iff (rst)
    done |-> (p < m_q));

  // R10: operand bound the reduction relies on
  a_r10_operand_bound: assert property (@(posedge clk) disable iff (rst)
    (start && st == M_IDLE) |-> ((a < m) || (m == W'(1))));
endmodule

// File: rtl/latency_timer.sv
`timescale 1ns/1ps
module latency_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          mark,
  input  logic          stop,
  output logic [CW-1:0] lat
);
  logic [CW-1:0] free_cnt, t0;

  always_ff @(posedge clk) begin
    if (rst) begin
      free_cnt <= '0;
      t0       <= '0;
      lat      <= '0;
    end else begin
      free_cnt <= free_cnt + 1'b1;
      if (mark) t0  <= free_cnt;
      if (stop) lat <= free_cnt - t0;
    end
  end

  // R3: a stop never coincides with a mark, so a latched span is never zero
  a_r3_span_nonzero: assert property (@(posedge clk) disable iff (rst)
    (stop && !mark) |=> (lat != '0));
endmodule

// File: rtl/modexp_core.sv
`timescale 1ns/1ps
module modexp_core
  import modexp_pkg::*;
#(
  parameter int    W         = 32,
  parameter arch_e ARCH      = ARCH_CONST,
  parameter bit    BAL_SUB   = 1'b0,
  parameter int    CT_CYCLES = 4500,
  parameter int    CW        = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [W-1:0]  base,
  input  logic [W-1:0]  expo,
  input  logic [W-1:0]  modulus,
  output logic          ready,
  output logic [W-1:0]  result,
  output logic [CW-1:0] latency
);
  localparam int IW     = $clog2(W);
  localparam int CTW    = $clog2(CT_CYCLES + 1);
  localparam bit UP     = (ARCH == ARCH_RTL);
  localparam bit PAD_EN = (ARCH == ARCH_CONST);
  localparam int L_BAL  = (2*W + 2) + (2*W + 3) * 2 * W + 1;

  typedef enum logic [2:0] {C_IDLE, C_RED, C_ISSUE, C_WAIT, C_PAD, C_DONE} cst_e;
  cst_e st;

  logic [W-1:0]   m_q, e_q, b_q, r0, r1, xb;
  logic [IW-1:0]  idx, idx_nx;
  logic           phase, ebit, last_bit, at_end;
  logic [CTW-1:0] ct;
  mulop_t         op;
  cst_e           st_after;

  logic           mul_start, mul_done;
  logic [W-1:0]   mul_a, mul_b, mul_p;

  assign ebit     = e_q[idx];
  assign last_bit = UP ? (idx == IW'(W - 1)) : (idx == '0);
  assign at_end   = phase && last_bit;
  assign idx_nx   = UP ? (idx + 1'b1) : (idx - 1'b1);
  assign st_after = at_end ? (PAD_EN ? C_PAD : C_DONE) : C_ISSUE;

  // Per-variant schedule of the two multiply slots of one exponent bit
  generate
    if (ARCH == ARCH_RTL) begin : g_rtl
      always_comb begin
        op = '0;
        if (!phase) begin
          op.run = ebit; op.wr = 1'b1; op.sa = SRC_R0; op.sb = SRC_R1; op.dst = 1'b0;
        end else begin
          op.run = 1'b1; op.wr = 1'b1; op.sa = SRC_R1; op.sb = SRC_R1; op.dst = 1'b1;
        end
      end
    end else if (ARCH == ARCH_LTR) begin : g_ltr
      always_comb begin
        op = '0;
        if (!phase) begin
          op.run = 1'b1; op.wr = 1'b1; op.sa = SRC_R0; op.sb = SRC_R0; op.dst = 1'b0;
        end else begin
          op.run = ebit; op.wr = 1'b1; op.sa = SRC_R0; op.sb = SRC_X;  op.dst = 1'b0;
        end
      end
    end else if (ARCH == ARCH_LADDER) begin : g_ladder
      always_comb begin
        op = '0;
        op.run = 1'b1;
        op.wr  = 1'b1;
        if (!phase) begin
          op.sa = SRC_R0; op.sb = SRC_R1; op.dst = ebit ? 1'b0 : 1'b1;
        end else begin
          op.sa  = ebit ? SRC_R1 : SRC_R0;
          op.sb  = ebit ? SRC_R1 : SRC_R0;
          op.dst = ebit;
        end
      end
    end else begin : g_always
      // always-multiply and constant-time share the balanced walk
      always_comb begin
        op = '0;
        op.run = 1'b1;
        if (!phase) begin
          op.wr = 1'b1; op.sa = SRC_R0; op.sb = SRC_R0; op.dst = 1'b0;
        end else begin
          op.wr = ebit; op.sa = SRC_R0; op.sb = SRC_X;  op.dst = 1'b0;
        end
      end
    end
  endgenerate

  function automatic logic [W-1:0] pick(input src_e s, input logic [W-1:0] v0,
                                        input logic [W-1:0] v1, input logic [W-1:0] vx);
    case (s)
      SRC_R0:  pick = v0;
      SRC_R1:  pick = v1;
      default: pick = vx;
    endcase
  endfunction

  assign mul_a = (st == C_RED) ? W'(1) : pick(op.sa, r0, r1, xb);
  assign mul_b = (st == C_RED) ? b_q   : pick(op.sb, r0, r1, xb);

  modmul_serial #(.W(W), .BAL_SUB(BAL_SUB)) u_mul (
    .clk   (clk),
    .rst   (rst),
    .start (mul_start),
    .a     (mul_a),
    .b     (mul_b),
    .m     (m_q),
    .done  (mul_done),
    .p     (mul_p)
  );

  latency_timer #(.CW(CW)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .mark (start && (st == C_IDLE)),
    .stop (st == C_DONE),
    .lat  (latency)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= C_IDLE;
      m_q       <= '0;
      e_q       <= '0;
      b_q       <= '0;
      r0        <= '0;
      r1        <= '0;
      xb        <= '0;
      idx       <= '0;
      phase     <= 1'b0;
      ct        <= '0;
      mul_start <= 1'b0;
      ready     <= 1'b0;
      result    <= '0;
    end else begin
      mul_start <= 1'b0;
      ready     <= 1'b0;
      ct        <= ct + 1'b1;
      case (st)
        C_IDLE: begin
          if (start) begin
            m_q   <= modulus;
            e_q   <= expo;
            b_q   <= base;
            ct    <= '0;
            phase <= 1'b0;
            idx   <= UP ? '0 : IW'(W - 1);
            if (modulus == '0) begin
              r0 <= '0;
              st <= C_DONE;
            end else begin
              mul_start <= 1'b1;
              st        <= C_RED;
            end
          end
        end
        C_RED: begin
          if (mul_done) begin
            xb <= mul_p;
            r1 <= mul_p;
            r0 <= (m_q == W'(1)) ? '0 : W'(1);
            st <= C_ISSUE;
          end
        end
        C_ISSUE: begin
          if (op.run) begin
            mul_start <= 1'b1;
            st        <= C_WAIT;
          end else begin
            if (!phase) phase <= 1'b1;
            else begin phase <= 1'b0; idx <= idx_nx; end
            st <= st_after;
          end
        end
        C_WAIT: begin
          if (mul_done) begin
            if (op.wr) begin
              if (op.dst) r1 <= mul_p;
              else        r0 <= mul_p;
            end
            if (!phase) phase <= 1'b1;
            else begin phase <= 1'b0; idx <= idx_nx; end
            st <= st_after;
          end
        end
        C_PAD: begin
          if (ct >= CTW'(CT_CYCLES - 2)) st <= C_DONE;
        end
        C_DONE: begin
          ready  <= 1'b1;
          result <= r0;
          st     <= C_IDLE;
        end
        default: st <= C_IDLE;
      endcase
    end
  end

  // R3: ready lasts one cycle
  a_r3_ready_pulse: assert property (@(posedge clk) disable iff (rst)
    ready |=> !ready);

  // R4: operands stay latched while busy
  a_r4_hold_operands: assert property (@(posedge clk) disable iff (rst)
    (st != C_IDLE) |=> ($stable(m_q) && $stable(e_q) && $stable(b_q)));

  // R2: zero modulus returns zero after a single cycle
  a_r2_zero_modulus: assert property (@(posedge clk) disable iff (rst)
    (ready && m_q == '0) |-> (result == '0 && latency == CW'(1)));

  generate
    if (PAD_EN) begin : g_ct_chk
      // R6: fixed latency for every nonzero modulus
      a_r6_const_latency: assert property (@(posedge clk) disable iff (rst)
        (ready && m_q != '0) |-> (latency == CW'(CT_CYCLES)));
    end
    if (BAL_SUB && (ARCH == ARCH_LTR_DUMMY || ARCH == ARCH_LADDER)) begin : g_bal_chk
      // R7: balanced walks have one latency for all operands
      a_r7_balanced_latency: assert property (@(posedge clk) disable iff (rst)
        (ready && m_q != '0) |-> (latency == CW'(L_BAL)));
    end
  endgenerate
endmodule

// File: tb/modexp_core_tb.sv
`timescale 1ns/1ps
module modexp_core_tb;
  import modexp_pkg::*;

  localparam int W    = 32;
  localparam int CW   = 16;
  localparam int NA   = 5;
  localparam int CT   = 4500;
  localparam int LBAL = (2*W + 2) + (2*W + 3) * 2 * W + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [W-1:0] base = '0, expo = '0, modu = '0;

  logic          rdy [NA];
  logic [W-1:0]  res [NA];
  logic [CW-1:0] lat [NA];

  int checks = 0;
  int errors = 0;
  int issued = 0;
  int got [NA];
  int last_lat [NA];
  logic prev_rdy [NA];
  logic [W-1:0] exp_res [NA][$];
  int exp_lat [NA][$];

  always #2.5 clk = ~clk;

  // one instance per architecture; 2 and 3 use the balanced multiplier
  for (genvar g = 0; g < NA; g++) begin : g_arch
    modexp_core #(
      .W(W), .ARCH(arch_e'(g)), .BAL_SUB(g == 2 || g == 3),
      .CT_CYCLES(CT), .CW(CW)
    ) u_dut (
      .clk(clk), .rst(rst), .start(start), .base(base), .expo(expo),
      .modulus(modu), .ready(rdy[g]), .result(res[g]), .latency(lat[g])
    );
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic logic [W-1:0] ref_pow(input logic [W-1:0] b, input logic [W-1:0] e,
                                           input logic [W-1:0] m);
    logic [63:0] r, x, mm;
    if (m == '0) return '0;
    mm = {32'd0, m};
    r  = 64'd1 % mm;
    x  = {32'd0, b} % mm;
    for (int k = 0; k < W; k++) begin
      if (e[k]) r = (r * x) % mm;
      x = (x * x) % mm;
    end
    return r[W-1:0];
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst) begin
      for (int i = 0; i < NA; i++) prev_rdy[i] = 1'b0;
    end else begin
      for (int i = 0; i < NA; i++) begin
        if (rdy[i]) begin
          chk(!prev_rdy[i], "R3", "ready longer than one cycle", 1, 0);
          if (exp_res[i].size() == 0) begin
            chk(1'b0, "R4", "unexpected ready", i, -1);
          end else begin
            logic [W-1:0] er;
            int el;
            er = exp_res[i].pop_front();
            el = exp_lat[i].pop_front();
            got[i]++;
            last_lat[i] = int'(lat[i]);
            chk(res[i] == er, "R1", "result", res[i], er);
            if (el == 1)
              chk(int'(lat[i]) == el, "R2", "zero-modulus latency", lat[i], el);
            else if (el == CT)
              chk(int'(lat[i]) == el, "R6", "constant-time latency", lat[i], el);
            else if (el >= 0)
              chk(int'(lat[i]) == el, "R7", "balanced latency", lat[i], el);
          end
        end
        prev_rdy[i] = rdy[i];
      end
    end
  end

  task automatic wait_all();
    int n = 0;
    bit pending = 1'b1;
    while (pending) begin
      @(negedge clk);
      n++;
      pending = 1'b0;
      for (int i = 0; i < NA; i++) if (got[i] < issued) pending = 1'b1;
      if (n > 20000) begin
        chk(1'b0, "R3", "ready never arrived", n, 0);
        pending = 1'b0;
      end
    end
  endtask

  task automatic launch(input logic [W-1:0] b, input logic [W-1:0] e,
                        input logic [W-1:0] m);
    @(negedge clk);
    base  = b;
    expo  = e;
    modu  = m;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_vec(input logic [W-1:0] b, input logic [W-1:0] e,
                         input logic [W-1:0] m);
    logic [W-1:0] r;
    r = ref_pow(b, e, m);
    for (int i = 0; i < NA; i++) begin
      exp_res[i].push_back(r);
      if (m == '0)          exp_lat[i].push_back(1);
      else if (i == 4)      exp_lat[i].push_back(CT);
      else if (i == 2 || i == 3) exp_lat[i].push_back(LBAL);
      else                  exp_lat[i].push_back(-1);
    end
    issued++;
    launch(b, e, m);
    wait_all();
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    chk(1'b0, "R3", "watchdog expired", 0, 1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int lz0, lz1;
    for (int i = 0; i < NA; i++) got[i] = 0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R5: reset state
    for (int i = 0; i < NA; i++) begin
      chk(rdy[i] == 1'b0, "R5", "ready after reset", rdy[i], 0);
      chk(res[i] == '0, "R5", "result after reset", res[i], 0);
      chk(lat[i] == '0, "R5", "latency after reset", lat[i], 0);
    end

    run_vec(32'd5, 32'd3, 32'd13);                    // R1 small case
    run_vec(32'hDEADBEEF, 32'h12345679, 32'hFFFFFFFB); // R1 wide modulus
    run_vec(32'hFFFFFFFF, 32'd65537, 32'd1000003);    // R1 base above modulus
    run_vec(32'd42, 32'd0, 32'd97);                   // R9 zero exponent
    run_vec(32'd12345, 32'hFFFF0000, 32'd1);          // R1 unit modulus
    run_vec(32'd77, 32'hA5A5A5A5, 32'd0);             // R2 zero modulus
    run_vec(32'd0, 32'd5, 32'd101);                   // R1 zero base
    run_vec(32'd3, 32'hFFFFFFFF, 32'h7FFFFFFF);       // R1 all-ones exponent
    for (int v = 0; v < 3; v++)
      run_vec($urandom, $urandom, $urandom | 32'h8000_0001); // R1 random

    // R8: unmitigated walks depend on the exponent
    run_vec(32'd7, 32'd0, 32'd1000003);
    lz0 = last_lat[0];
    lz1 = last_lat[1];
    run_vec(32'd7, 32'hFFFFFFFF, 32'd1000003);
    chk(last_lat[0] > lz0, "R8", "right-to-left latency grows", last_lat[0], lz0 + 1);
    chk(last_lat[1] > lz1, "R8", "left-to-right latency grows", last_lat[1], lz1 + 1);

    // R4: second start while busy is ignored
    begin
      logic [W-1:0] r;
      r = ref_pow(32'd9, 32'hC0FFEE11, 32'd2147483629);
      for (int i = 0; i < NA; i++) begin
        exp_res[i].push_back(r);
        exp_lat[i].push_back(i == 4 ? CT : ((i == 2 || i == 3) ? LBAL : -1));
      end
      issued++;
      launch(32'd9, 32'hC0FFEE11, 32'd2147483629);
      repeat (20) @(negedge clk);
      launch(32'd1234, 32'd99, 32'd55);
      wait_all();
      repeat (300) @(negedge clk);
      for (int i = 0; i < NA; i++)
        chk(got[i] == issued, "R4", "ready count after busy start", got[i], issued);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule